// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits between a bank of 16-bit counter channels and the connector pins that serve them. It chooses, for each channel, where the counting clock comes from and what gates it. Channels come in groups of three. The number of groups is a parameter. Each channel holds two 3-bit selection codes, one for the clock and one for the gate. Software writes and reads the codes through a small register port. The counters and the host bus decoding sit outside this block.

The clock choices for a channel are its own connector pin, five internal rates, the output of the preceding channel, and an input that the three channels of a group share. The five internal rates are 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. They come from a decade prescaler as single-cycle enable pulses on the system clock, so no new clock domain is added. The gate choices are always on, always off, the channel's own connector pin, and the inverted output of a partner channel. Groups are linked in a ring, so the highest group feeds the lowest.

A connector pin is an input only while its channel selects it. For any other code the block drives the selected signal onto that pin and raises the pin's output enable. Every interface here is a plain control or level signal. No data stream flows, so there is no valid/ready handshake and no back-pressure.

Top module: `ctr_route`

## Requirements
- R1: After reset every clock code and every gate code reads 0. Each channel's clock follows its own clock pin, every gate is enabled (1), all clock-pin enables are 0 and all gate-pin enables are 1.
- R2: A cycle with `wr_en` high stores `wr_code` in the channel at `wr_addr`. It goes to the clock code when `wr_field` is 0 and to the gate code when `wr_field` is 1. `rd_clk_code` and `rd_gate_code` show the codes of channel `rd_addr`. A write to an address of NUM_CH or above changes no code.
- R3: Clock codes 1, 2, 3, 4 and 5 give single-cycle pulses. Their periods are PRE_DIV×1, PRE_DIV×10, PRE_DIV×100, PRE_DIV×1000 and PRE_DIV×10000 system clock cycles.
- R4: Clock code 0 passes the channel's own `ext_clk_in` bit through. Clock code 7 passes the `grp_clk_in` bit of the channel's group, where group = channel index / 3.
- R5: Clock code 6 passes `ctr_out_in` of channel index−1. Channel 0 of group g takes channel 2 of group g−1. Group 0 takes the highest group, which closes the ring.
- R6: Gate code 0 gives gate 1. Gate code 1 gives gate 0. Gate code 2 passes the channel's own `ext_gate_in` bit through.
- R7: Gate code 3 gives the inverse of a partner channel's `ctr_out_in`. For channel 2 of a group the partner is channel 0 of the same group. For channels 0 and 1 the partner is channel n+1 of the preceding group in the ring.
- R8: Gate codes 4 to 7 give gate 0 whatever the gate pin does.
- R9: `clk_pin_oe` of a channel is 1 exactly when its clock code is not 0. `gate_pin_oe` is 1 exactly when its gate code is not 2. `clk_pin_out` and `gate_pin_out` carry the selected clock and gate.
- R10: A code written at a clock edge takes effect on the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; base for the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one selection code |
| wr_addr | input | ADDR_W | Channel index to write |
| wr_field | input | 1 | 0 = clock code, 1 = gate code |
| wr_code | input | 3 | Code value to store |
| rd_addr | input | ADDR_W | Channel index to read back |
| rd_clk_code | output | 3 | Clock code of channel rd_addr |
| rd_gate_code | output | 3 | Gate code of channel rd_addr |
| ext_clk_in | input | NUM_CH | Per-channel clock pin, as received |
| ext_gate_in | input | NUM_CH | Per-channel gate pin, as received |
| grp_clk_in | input | NUM_GRP | Shared clock input, one per group |
| ctr_out_in | input | NUM_CH | Outputs of the counter channels |
| ctr_clk | output | NUM_CH | Selected clock (level or enable pulse) per channel |
| ctr_gate | output | NUM_CH | Selected gate per channel |
| clk_pin_out | output | NUM_CH | Value to drive onto each clock pin |
| clk_pin_oe | output | NUM_CH | Clock pin output enable |
| gate_pin_out | output | NUM_CH | Value to drive onto each gate pin |
| gate_pin_oe | output | NUM_CH | Gate pin output enable |

## Verification
The assertions take the pin inputs, group clocks and counter outputs to be synchronous to the system clock and free of unknown values. They also assume that reset is held high from time zero, so the register and prescaler state is known before any property is checked. The bench meets both conditions. It changes every input only on the falling edge and drives every bit to a defined 0 or 1. It asserts reset before the first rising edge. The ring and partner-channel checks flip a single counter output and hold the rest at the opposite level, so an off-by-one in the routing shows up.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int CH_PER_GRP = 3;
  localparam int CODE_W     = 3;
  localparam int NUM_TAPS   = 5;
  localparam int DECADE     = 10;

  typedef enum logic [CODE_W-1:0] {
    CK_PIN   = 3'd0,
    CK_TAP0  = 3'd1,
    CK_TAP1  = 3'd2,
    CK_TAP2  = 3'd3,
    CK_TAP3  = 3'd4,
    CK_TAP4  = 3'd5,
    CK_CHAIN = 3'd6,
    CK_GROUP = 3'd7
  } clk_sel_e;

  typedef enum logic [CODE_W-1:0] {
    GT_HIGH  = 3'd0,
    GT_LOW   = 3'd1,
    GT_PIN   = 3'd2,
    GT_INVPR = 3'd3
  } gate_sel_e;

  // Index of the channel whose output clocks channel idx (ring order).
  function automatic int chain_clk_src(input int idx, input int n_ch);
    return (idx + n_ch - 1) % n_ch;
  endfunction

  // Index of the channel whose inverted output gates channel idx.
  function automatic int chain_gate_src(input int idx, input int n_grp);
    int g;
    int c;
    g = idx / CH_PER_GRP;
    c = idx % CH_PER_GRP;
    if (c == CH_PER_GRP - 1)
      return g * CH_PER_GRP;
    return ((g + n_grp - 1) % n_grp) * CH_PER_GRP + c + 1;
  endfunction

endpackage

// File: rtl/ctr_decade_prescaler.sv
module ctr_decade_prescaler #(
  parameter int PRE_DIV  = 2,
  parameter int NUM_TAPS = 5,
  parameter int DECADE   = 10
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tick
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int DW = $clog2(DECADE);

  logic [PW-1:0] pre_cnt;
  logic          pre_wrap;

  assign pre_wrap = (pre_cnt == PW'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_stage
    logic stage_tick;

    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_tick <= 1'b0;
        else     stage_tick <= pre_wrap;
      end
    end else begin : g_decade
      logic [DW-1:0] dec_cnt;
      logic          dec_last;

      assign dec_last = (dec_cnt == DW'(DECADE - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          dec_cnt    <= '0;
          stage_tick <= 1'b0;
        end else begin
          stage_tick <= tick[k-1] && dec_last;
          if (tick[k-1]) begin
            dec_cnt <= dec_last ? '0 : dec_cnt + 1'b1;
          end
        end
      end
    end

    assign tick[k] = stage_tick;
  end

endmodule

// File: rtl/ctr_sel_regs.sv
module ctr_sel_regs #(
  parameter int NUM_CH = 6,
  parameter int CODE_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic                           wr_field,
  input  logic [CODE_W-1:0]              wr_code,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [CODE_W-1:0]              rd_clk_code,
  output logic [CODE_W-1:0]              rd_gate_code,
  output logic [NUM_CH-1:0][CODE_W-1:0]  clk_codes,
  output logic [NUM_CH-1:0][CODE_W-1:0]  gate_codes
);

  logic wr_in_range;
  logic rd_in_range;

  assign wr_in_range = ({1'b0, wr_addr} < (ADDR_W + 1)'(NUM_CH));
  assign rd_in_range = ({1'b0, rd_addr} < (ADDR_W + 1)'(NUM_CH));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic hit;
    assign hit = wr_en && wr_in_range && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        clk_codes[i]  <= '0;
        gate_codes[i] <= '0;
      end else if (hit) begin
        if (wr_field) gate_codes[i] <= wr_code;
        else          clk_codes[i]  <= wr_code;
      end
    end
  end

  always_comb begin
    rd_clk_code  = '0;
    rd_gate_code = '0;
    if (rd_in_range) begin
      rd_clk_code  = clk_codes[rd_addr];
      rd_gate_code = gate_codes[rd_addr];
    end
  end

endmodule

// File: rtl/ctr_chan_route.sv
module ctr_chan_route
  import ctr_route_pkg::*;
#(
  parameter int NUM_TAPS = 5
) (
  input  logic [CODE_W-1:0]   clk_code,
  input  logic [CODE_W-1:0]   gate_code,
  input  logic [NUM_TAPS-1:0] tick,
  input  logic                pin_clk,
  input  logic                pin_gate,
  input  logic                grp_clk,
  input  logic                chain_out,
  input  logic                partner_out,
  output logic                sel_clk,
  output logic                sel_gate,
  output logic                clk_oe,
  output logic                gate_oe
);

  always_comb begin
    unique case (clk_sel_e'(clk_code))
      CK_PIN:   sel_clk = pin_clk;
      CK_TAP0:  sel_clk = tick[0];
      CK_TAP1:  sel_clk = tick[1];
      CK_TAP2:  sel_clk = tick[2];
      CK_TAP3:  sel_clk = tick[3];
      CK_TAP4:  sel_clk = tick[4];
      CK_CHAIN: sel_clk = chain_out;
      CK_GROUP: sel_clk = grp_clk;
      default:  sel_clk = 1'b0;
    endcase
  end

  always_comb begin
    case (gate_code)
      GT_HIGH:  sel_gate = 1'b1;
      GT_LOW:   sel_gate = 1'b0;
      GT_PIN:   sel_gate = pin_gate;
      GT_INVPR: sel_gate = ~partner_out;
      default:  sel_gate = 1'b0;
    endcase
  end

  assign clk_oe  = (clk_code != CK_PIN);
  assign gate_oe = (gate_code != GT_PIN);

endmodule

// File: rtl/ctr_route.sv
module ctr_route
  import ctr_route_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int PRE_DIV = 2,
  localparam int NUM_CH = NUM_GRP * CH_PER_GRP,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_field,
  input  logic [2:0]        wr_code,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        rd_clk_code,
  output logic [2:0]        rd_gate_code,
  input  logic [NUM_CH-1:0] ext_clk_in,
  input  logic [NUM_CH-1:0] ext_gate_in,
  input  logic [NUM_GRP-1:0] grp_clk_in,
  input  logic [NUM_CH-1:0] ctr_out_in,
  output logic [NUM_CH-1:0] ctr_clk,
  output logic [NUM_CH-1:0] ctr_gate,
  output logic [NUM_CH-1:0] clk_pin_out,
  output logic [NUM_CH-1:0] clk_pin_oe,
  output logic [NUM_CH-1:0] gate_pin_out,
  output logic [NUM_CH-1:0] gate_pin_oe
);

  logic [NUM_TAPS-1:0]               tick;
  logic [NUM_CH-1:0][CODE_W-1:0]     clk_codes;
  logic [NUM_CH-1:0][CODE_W-1:0]     gate_codes;

  ctr_decade_prescaler #(
    .PRE_DIV (PRE_DIV),
    .NUM_TAPS(NUM_TAPS),
    .DECADE  (DECADE)
  ) u_prescale (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ctr_sel_regs #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_field    (wr_field),
    .wr_code     (wr_code),
    .rd_addr     (rd_addr),
    .rd_clk_code (rd_clk_code),
    .rd_gate_code(rd_gate_code),
    .clk_codes   (clk_codes),
    .gate_codes  (gate_codes)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    localparam int CLK_SRC  = chain_clk_src(i, NUM_CH);
    localparam int GATE_SRC = chain_gate_src(i, NUM_GRP);
    localparam int GRP      = i / CH_PER_GRP;

    ctr_chan_route #(
      .NUM_TAPS(NUM_TAPS)
    ) u_chan (
      .clk_code   (clk_codes[i]),
      .gate_code  (gate_codes[i]),
      .tick       (tick),
      .pin_clk    (ext_clk_in[i]),
      .pin_gate   (ext_gate_in[i]),
      .grp_clk    (grp_clk_in[GRP]),
      .chain_out  (ctr_out_in[CLK_SRC]),
      .partner_out(ctr_out_in[GATE_SRC]),
      .sel_clk    (ctr_clk[i]),
      .sel_gate   (ctr_gate[i]),
      .clk_oe     (clk_pin_oe[i]),
      .gate_oe    (gate_pin_oe[i])
    );
  end

  assign clk_pin_out  = ctr_clk;
  assign gate_pin_out = ctr_gate;

endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk #(
  parameter int NUM_GRP  = 2,
  parameter int NUM_TAPS = 5,
  parameter int NUM_CH   = 6,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic                wr_field,
  input logic [2:0]          wr_code,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [2:0]          rd_clk_code,
  input logic [NUM_CH-1:0]   ext_clk_in,
  input logic [NUM_CH-1:0]   ext_gate_in,
  input logic [NUM_CH-1:0]   ctr_clk,
  input logic [NUM_CH-1:0]   ctr_gate,
  input logic [NUM_CH-1:0]   clk_pin_oe,
  input logic [NUM_CH-1:0]   gate_pin_oe,
  input logic [NUM_TAPS-1:0] tick
);

  logic wr_ok;
  assign wr_ok = wr_en && ({1'b0, wr_addr} < (ADDR_W + 1)'(NUM_CH));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_pin_oe == '0) && (gate_pin_oe == '1) && (ctr_gate == '1));

  // R2
  clk_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !wr_field) |=> (rd_addr != $past(wr_addr)) || (rd_clk_code == $past(wr_code)));

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    // R3
    tick_cascade_chk: assert property (@(posedge clk) disable iff (rst)
      tick[k] |-> $past(tick[k-1]));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R4
    clk_pin_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !clk_pin_oe[i] |-> (ctr_clk[i] == ext_clk_in[i]));

    // R6
    gate_pin_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !gate_pin_oe[i] |-> (ctr_gate[i] == ext_gate_in[i]));

    // R8
    rsvd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && wr_field && wr_addr == ADDR_W'(i) && wr_code[2])
        |=> (!ctr_gate[i] && gate_pin_oe[i]));

    // R10
    clk_code0_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && !wr_field && wr_addr == ADDR_W'(i) && wr_code == 3'd0)
        |=> !clk_pin_oe[i]);

    // R9
    gate_code2_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && wr_field && wr_addr == ADDR_W'(i) && wr_code != 3'd2)
        |=> gate_pin_oe[i]);
  end

endmodule

bind ctr_route ctr_route_chk #(
  .NUM_GRP (NUM_GRP),
  .NUM_TAPS(ctr_route_pkg::NUM_TAPS),
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_field   (wr_field),
  .wr_code    (wr_code),
  .rd_addr    (rd_addr),
  .rd_clk_code(rd_clk_code),
  .ext_clk_in (ext_clk_in),
  .ext_gate_in(ext_gate_in),
  .ctr_clk    (ctr_clk),
  .ctr_gate   (ctr_gate),
  .clk_pin_oe (clk_pin_oe),
  .gate_pin_oe(gate_pin_oe),
  .tick       (tick)
);

// File: tb/ctr_route_bench.sv
module ctr_route_bench;

  localparam int NUM_GRP = 2;
  localparam int PRE_DIV = 2;
  localparam int NUM_CH  = 6;
  localparam int ADDR_W  = 3;

  typedef struct packed {
    logic [2:0] ch;
    logic [2:0] cc;
    logic [2:0] gc;
    logic [5:0] co;
    logic [5:0] ec;
    logic [5:0] eg;
    logic [1:0] gx;
    logic       e_clk;
    logic       e_gate;
    logic       e_coe;
    logic       e_goe;
  } vec_t;

  localparam int NV = 17;
  // ch, clk code, gate code, ctr_out, ext_clk, ext_gate, grp_clk, exp clk/gate/clk_oe/gate_oe
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 3'd0, 6'b000000, 6'b000001, 6'b000000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 R6
    '{3'd0, 3'd0, 3'd0, 6'b111111, 6'b111110, 6'b111111, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 R6
    '{3'd0, 3'd6, 3'd1, 6'b100000, 6'b000000, 6'b000000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 ring wrap
    '{3'd0, 3'd6, 3'd1, 6'b011111, 6'b111111, 6'b111111, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{3'd4, 3'd6, 3'd2, 6'b001000, 6'b000000, 6'b010000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 R6
    '{3'd3, 3'd6, 3'd2, 6'b000100, 6'b000000, 6'b000000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 cross group
    '{3'd1, 3'd7, 3'd0, 6'b000000, 6'b000000, 6'b000000, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 group clk
    '{3'd1, 3'd7, 3'd0, 6'b111111, 6'b111111, 6'b000000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
    '{3'd4, 3'd7, 3'd0, 6'b000000, 6'b000000, 6'b000000, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1}, // R4
    '{3'd2, 3'd0, 3'd3, 6'b000001, 6'b000100, 6'b000000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{3'd2, 3'd0, 3'd3, 6'b111110, 6'b000000, 6'b000000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1}, // R7
    '{3'd0, 3'd0, 3'd3, 6'b010000, 6'b000000, 6'b000000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 ring
    '{3'd0, 3'd0, 3'd3, 6'b101111, 6'b000000, 6'b000000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1}, // R7
    '{3'd4, 3'd0, 3'd3, 6'b000100, 6'b000000, 6'b000000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    '{3'd3, 3'd0, 3'd3, 6'b000010, 6'b000000, 6'b000000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    '{3'd1, 3'd0, 3'd5, 6'b000000, 6'b000010, 6'b111111, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{3'd5, 3'd0, 3'd7, 6'b000000, 6'b000000, 6'b111111, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}  // R8
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic              wr_field = 1'b0;
  logic [2:0]        wr_code = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [2:0]        rd_clk_code;
  logic [2:0]        rd_gate_code;
  logic [NUM_CH-1:0] ext_clk_in = '0;
  logic [NUM_CH-1:0] ext_gate_in = '0;
  logic [NUM_GRP-1:0] grp_clk_in = '0;
  logic [NUM_CH-1:0] ctr_out_in = '0;
  logic [NUM_CH-1:0] ctr_clk;
  logic [NUM_CH-1:0] ctr_gate;
  logic [NUM_CH-1:0] clk_pin_out;
  logic [NUM_CH-1:0] clk_pin_oe;
  logic [NUM_CH-1:0] gate_pin_out;
  logic [NUM_CH-1:0] gate_pin_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctr_route #(.NUM_GRP(NUM_GRP), .PRE_DIV(PRE_DIV)) u_ctr_route (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_field    (wr_field),
    .wr_code     (wr_code),
    .rd_addr     (rd_addr),
    .rd_clk_code (rd_clk_code),
    .rd_gate_code(rd_gate_code),
    .ext_clk_in  (ext_clk_in),
    .ext_gate_in (ext_gate_in),
    .grp_clk_in  (grp_clk_in),
    .ctr_out_in  (ctr_out_in),
    .ctr_clk     (ctr_clk),
    .ctr_gate    (ctr_gate),
    .clk_pin_out (clk_pin_out),
    .clk_pin_oe  (clk_pin_oe),
    .gate_pin_out(gate_pin_out),
    .gate_pin_oe (gate_pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_code(input int ch, input bit field, input int code);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_addr  = ADDR_W'(ch);
    wr_field = field;
    wr_code  = 3'(code);
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  // Cycles between two consecutive pulses on ctr_clk[ch], sampled at negedges.
  task automatic measure_period(input int ch, output int period);
    int cnt;
    @(negedge clk);
    while (!ctr_clk[ch]) @(negedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ctr_clk[ch]);
    period = cnt;
  endtask

  initial begin
    int per;
    int exp_per;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NUM_CH; i++) begin
      rd_addr = ADDR_W'(i);
      #1;
      check("R1 clk code", int'(rd_clk_code), 0);
      check("R1 gate code", int'(rd_gate_code), 0);
    end
    ext_clk_in = 6'b101010;
    #1;
    check("R1 clk follows pin", int'(ctr_clk), 6'b101010);
    check("R1 gate enabled", int'(ctr_gate), 6'b111111);
    check("R1 clk_pin_oe", int'(clk_pin_oe), 0);
    check("R1 gate_pin_oe", int'(gate_pin_oe), 6'b111111);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      write_code(int'(VECS[v].ch), 1'b0, int'(VECS[v].cc));
      write_code(int'(VECS[v].ch), 1'b1, int'(VECS[v].gc));
      ctr_out_in  = VECS[v].co;
      ext_clk_in  = VECS[v].ec;
      ext_gate_in = VECS[v].eg;
      grp_clk_in  = VECS[v].gx;
      rd_addr     = ADDR_W'(VECS[v].ch);
      #1;
      check("R2 clk readback", int'(rd_clk_code), int'(VECS[v].cc));
      check("R2 gate readback", int'(rd_gate_code), int'(VECS[v].gc));
      check("R4-R8 vector clk", int'(ctr_clk[VECS[v].ch]), int'(VECS[v].e_clk));
      check("R6-R8 vector gate", int'(ctr_gate[VECS[v].ch]), int'(VECS[v].e_gate));
      check("R9 clk_pin_oe", int'(clk_pin_oe[VECS[v].ch]), int'(VECS[v].e_coe));
      check("R9 gate_pin_oe", int'(gate_pin_oe[VECS[v].ch]), int'(VECS[v].e_goe));
      check("R9 clk_pin_out", int'(clk_pin_out[VECS[v].ch]), int'(VECS[v].e_clk));
      check("R9 gate_pin_out", int'(gate_pin_out[VECS[v].ch]), int'(VECS[v].e_gate));
    end

    // R2: out-of-range write ignored; every channel keeps its code
    write_code(6, 1'b0, 5);
    write_code(7, 1'b1, 3);
    for (int i = 0; i < NUM_CH; i++) begin
      rd_addr = ADDR_W'(i);
      #1;
      check("R2 no change clk", int'(rd_clk_code),
            (i == 0) ? 0 : (i == 1) ? 0 : (i == 2) ? 0 : (i == 3) ? 0 : (i == 4) ? 0 : 0);
    end
    rd_addr = 3'd5;
    #1;
    check("R2 no change gate ch5", int'(rd_gate_code), 7);

    // R10: write takes effect only after the clock edge
    ext_clk_in = '0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_field = 1'b0; wr_code = 3'd6;
    #1;
    check("R10 before edge", int'(clk_pin_oe[5]), 0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R10 after edge", int'(clk_pin_oe[5]), 1);
    write_code(5, 1'b0, 0);
    #1;
    check("R10 back to pin", int'(clk_pin_oe[5]), 0);

    // R3: internal rates
    exp_per = PRE_DIV;
    for (int code = 1; code <= 5; code++) begin
      write_code(2, 1'b0, code);
      measure_period(2, per);
      check("R3 period", per, exp_per);
      @(negedge clk);
      check("R3 single-cycle pulse", int'(ctr_clk[2]), (code == 1 && PRE_DIV == 1) ? 1 : 0);
      exp_per = exp_per * 10;
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule